// File: doc/BRIEF.md
# Debug monitor entry and host handshake

This block decides, at the moment the chip's reset pin is released, whether the device comes up in its debug monitor mode. Three pin and vector combinations select monitor mode, and each one also fixes which reference clock is assumed. After reset release the decision holds, whatever those pins do. If monitor mode is chosen, the block runs the opening exchange with a host over one shared open-drain serial line. It takes in eight bytes from the host and hands each one to external comparison logic. It then answers with a long low break, and finally signals that command handling may begin.

The line is wired-OR. The block only ever pulls it low and a pull-up restores the high level, so the block must not treat its own break as incoming traffic. The serial rate is the same in every entry case. The bit-period divisor therefore follows the clock case that was latched. The divisors are parameters, `BIT_CYC_4M` and `BIT_CYC_8M`, given in system clock cycles per bit.

Top module: `mon_handshake`

## Requirements
- R1: The monitor flag and the divider select change only on a clock edge where the reset pin is seen high and was low on the previous edge. Between such edges they hold, whatever the mode pins, the high-voltage flag or the vector flag do.
- R2: Entry case A: vector programmed (`vec_erased`=0), `irq_hv`=1, `irq_level`=1 and `mode_sel`=0. This sets `mon_mode`=1 and `clk_div_sel`=0, which means a bit period of `BIT_CYC_4M` cycles.
- R3: Entry case B is the same as case A but with `mode_sel`=1. It sets `mon_mode`=1 and `clk_div_sel`=1, which means a bit period of `BIT_CYC_8M` cycles.
- R4: Entry case C: `vec_erased`=1 and `irq_hv`=0, with `irq_level` either high or low. It sets `mon_mode`=1 and `clk_div_sel`=1.
- R5: When no entry case holds at release, `mon_mode`=0 and `clk_div_sel`=0. The line stays released and no byte is reported. After the synchronous reset `rst`, all outputs are 0.
- R6: The receiver accepts frames of one low start bit, eight data bits sent least significant bit first, and one high stop bit. Each bit lasts one latched bit period, and the receiver samples each bit at mid-bit.
- R7: Each accepted byte gives a one-cycle `sec_valid` together with `sec_data` and `sec_idx`, where the index counts 0 to 7 in arrival order. Let E be the first clock edge after the start bit falls and N the bit period. `sec_valid` is high for one cycle, following edge E + N/2 + 9N + 2.
- R8: A frame whose stop bit is low is discarded. It produces no `sec_valid` and does not advance the index.
- R9: Let V be the edge that raises `sec_valid` for index 7. `line_pd` is high after edges V+1 through V+10N, which is ten bit periods of low.
- R10: `cmd_ready` is high for exactly one cycle, following edge V+10N+2, and it comes once per handshake.
- R11: The line input is ignored from the eighth byte onward, including during the block's own break. No further `sec_valid` appears.
- R12: While the reset pin is low, the exchange is abandoned and `line_pd` is 0 from the next edge. The next release starts a fresh intake at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_pin_n | input | 1 | Chip reset pin level, low = reset |
| irq_hv | input | 1 | High voltage detected on the interrupt pin |
| irq_level | input | 1 | Logic level of the interrupt pin |
| mode_sel | input | 1 | Mode-select pin level |
| vec_erased | input | 1 | Both reset-vector bytes read as 0xFF |
| line_in | input | 1 | Level of the shared serial line |
| mon_mode | output | 1 | Monitor mode latched |
| line_pd | output | 1 | Open-drain pull-down enable for the line |
| clk_div_sel | output | 1 | 1 = 8 MHz case, 0 = 4 MHz case |
| sec_data | output | DATA_W | Received security byte |
| sec_valid | output | 1 | One-cycle strobe for sec_data |
| sec_idx | output | $clog2(NUM_SEC) | Position of the byte, 0 to 7 |
| cmd_ready | output | 1 | One-cycle pulse when commands may start |

## Verification
A wrong divisor choice or a wrongly latched entry case shows at once on `mon_mode` and `clk_div_sel`, one edge after release. It also shows within the first byte as a `sec_valid` at the wrong cycle or with the wrong data. A skipped or doubled index shows at the next strobe. An intake counter that stops early or late moves the start of `line_pd` by a whole frame, and a bad break counter moves its end and `cmd_ready` by at least one cycle. A receiver left enabled during the break shows as an extra strobe while `line_pd` is high.

// File: rtl/mon_pkg.sv
package mon_pkg;

  typedef enum logic [1:0] {
    SEQ_OFF,
    SEQ_INTAKE,
    SEQ_BREAK,
    SEQ_CMD
  } seq_e;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_e;

endpackage

// File: rtl/mon_entry_latch.sv
module mon_entry_latch (
  input  logic clk,
  input  logic rst,
  input  logic rise,
  input  logic vec_erased,
  input  logic irq_hv,
  input  logic irq_level,
  input  logic mode_sel,
  output logic grant,
  output logic mon_q,
  output logic fast_q
);

  logic case_a, case_b, case_c;

  // high voltage implies a high pin; a flag with a low pin is rejected
  assign case_a = !vec_erased && irq_hv && irq_level && !mode_sel;
  assign case_b = !vec_erased && irq_hv && irq_level &&  mode_sel;
  assign case_c =  vec_erased && !irq_hv;
  assign grant  = case_a || case_b || case_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      mon_q  <= 1'b0;
      fast_q <= 1'b0;
    end else if (rise) begin
      mon_q  <= grant;
      fast_q <= case_b || case_c;
    end
  end

endmodule

// File: rtl/mon_rx.sv
module mon_rx
  import mon_pkg::*;
#(
  parameter int CW     = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              line_q,
  input  logic [CW-1:0]     bit_cyc,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);

  localparam int BW = $clog2(DATA_W);

  rx_e               st;
  logic [CW-1:0]     cyc;
  logic [BW-1:0]     bitn;
  logic [DATA_W-1:0] shreg;
  logic [CW-1:0]     half_cyc;
  logic              cyc_end;

  assign half_cyc = bit_cyc >> 1;
  assign cyc_end  = (cyc == bit_cyc - CW'(1));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st      <= RX_IDLE;
      cyc     <= '0;
      bitn    <= '0;
      shreg   <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= 1'b0;
      case (st)
        RX_IDLE: begin
          cyc <= '0;
          if (!line_q) st <= RX_START;
        end
        RX_START: begin
          if (cyc == half_cyc - CW'(1)) begin
            cyc  <= '0;
            bitn <= '0;
            st   <= line_q ? RX_IDLE : RX_DATA;
          end else begin
            cyc <= cyc + CW'(1);
          end
        end
        RX_DATA: begin
          if (cyc_end) begin
            cyc   <= '0;
            shreg <= {line_q, shreg[DATA_W-1:1]};
            if (bitn == BW'(DATA_W - 1)) st <= RX_STOP;
            else                         bitn <= bitn + BW'(1);
          end else begin
            cyc <= cyc + CW'(1);
          end
        end
        RX_STOP: begin
          if (cyc_end) begin
            cyc <= '0;
            st  <= RX_IDLE;
            if (line_q) begin
              valid_o <= 1'b1;
              data_o  <= shreg;
            end
          end else begin
            cyc <= cyc + CW'(1);
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mon_brk_tx.sv
module mon_brk_tx #(
  parameter int CW       = 11,
  parameter int BRK_BITS = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          abort,
  input  logic          start,
  input  logic [CW-1:0] bit_cyc,
  output logic          pd_o,
  output logic          done_o
);

  localparam int BW = $clog2(BRK_BITS + 1);

  logic          busy;
  logic [CW-1:0] cyc;
  logic [BW-1:0] bits;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      busy   <= 1'b0;
      cyc    <= '0;
      bits   <= '0;
      pd_o   <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        pd_o <= 1'b1;
        cyc  <= '0;
        bits <= '0;
      end else if (busy) begin
        if (cyc == bit_cyc - CW'(1)) begin
          cyc <= '0;
          if (bits == BW'(BRK_BITS - 1)) begin
            busy   <= 1'b0;
            pd_o   <= 1'b0;
            done_o <= 1'b1;
          end else begin
            bits <= bits + BW'(1);
          end
        end else begin
          cyc <= cyc + CW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/mon_handshake.sv
module mon_handshake
  import mon_pkg::*;
#(
  parameter int BIT_CYC_4M = 556,
  parameter int BIT_CYC_8M = 1111,
  parameter int NUM_SEC    = 8,
  parameter int BRK_BITS   = 10,
  parameter int DATA_W     = 8,
  localparam int IW        = $clog2(NUM_SEC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rst_pin_n,
  input  logic              irq_hv,
  input  logic              irq_level,
  input  logic              mode_sel,
  input  logic              vec_erased,
  input  logic              line_in,
  output logic              mon_mode,
  output logic              line_pd,
  output logic              clk_div_sel,
  output logic [DATA_W-1:0] sec_data,
  output logic              sec_valid,
  output logic [IW-1:0]     sec_idx,
  output logic              cmd_ready
);

  localparam int MAXC = (BIT_CYC_8M > BIT_CYC_4M) ? BIT_CYC_8M : BIT_CYC_4M;
  localparam int CW   = $clog2(MAXC + 1);

  seq_e              st;
  logic              pin_q, line_q, rise, grant;
  logic [CW-1:0]     bit_cyc;
  logic [IW-1:0]     cnt;
  logic              rx_valid, tx_start, tx_done;
  logic [DATA_W-1:0] rx_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q  <= 1'b1;
      line_q <= 1'b1;
    end else begin
      pin_q  <= rst_pin_n;
      line_q <= line_in;
    end
  end

  assign rise    = rst_pin_n && !pin_q;
  assign bit_cyc = clk_div_sel ? CW'(BIT_CYC_8M) : CW'(BIT_CYC_4M);

  mon_entry_latch i_entry (
    .clk        (clk),
    .rst        (rst),
    .rise       (rise),
    .vec_erased (vec_erased),
    .irq_hv     (irq_hv),
    .irq_level  (irq_level),
    .mode_sel   (mode_sel),
    .grant      (grant),
    .mon_q      (mon_mode),
    .fast_q     (clk_div_sel)
  );

  mon_rx #(.CW(CW), .DATA_W(DATA_W)) i_rx (
    .clk     (clk),
    .rst     (rst),
    .en      ((st == SEQ_INTAKE) && rst_pin_n),
    .line_q  (line_q),
    .bit_cyc (bit_cyc),
    .valid_o (rx_valid),
    .data_o  (rx_data)
  );

  mon_brk_tx #(.CW(CW), .BRK_BITS(BRK_BITS)) i_tx (
    .clk     (clk),
    .rst     (rst),
    .abort   (!rst_pin_n),
    .start   (tx_start),
    .bit_cyc (bit_cyc),
    .pd_o    (line_pd),
    .done_o  (tx_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= SEQ_OFF;
      cnt       <= '0;
      sec_valid <= 1'b0;
      sec_data  <= '0;
      sec_idx   <= '0;
      tx_start  <= 1'b0;
      cmd_ready <= 1'b0;
    end else begin
      sec_valid <= 1'b0;
      tx_start  <= 1'b0;
      cmd_ready <= 1'b0;
      if (!rst_pin_n) begin
        st  <= SEQ_OFF;
        cnt <= '0;
      end else if (rise) begin
        st  <= grant ? SEQ_INTAKE : SEQ_OFF;
        cnt <= '0;
      end else begin
        case (st)
          SEQ_INTAKE: if (rx_valid) begin
            sec_valid <= 1'b1;
            sec_data  <= rx_data;
            sec_idx   <= cnt;
            if (cnt == IW'(NUM_SEC - 1)) begin
              st       <= SEQ_BREAK;
              tx_start <= 1'b1;
            end else begin
              cnt <= cnt + IW'(1);
            end
          end
          SEQ_BREAK: if (tx_done) begin
            st        <= SEQ_CMD;
            cmd_ready <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/mon_handshake_chk.sv
module mon_handshake_chk (
  input logic clk,
  input logic rst,
  input logic rst_pin_n,
  input logic mon_mode,
  input logic clk_div_sel,
  input logic line_pd,
  input logic sec_valid,
  input logic cmd_ready
);

  // R1
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !($past(rst_pin_n) && !$past(rst_pin_n, 2)) |-> ($stable(mon_mode) && $stable(clk_div_sel)));

  // R5
  sel_needs_mode_chk: assert property (@(posedge clk) disable iff (rst)
    clk_div_sel |-> mon_mode);

  // R9
  pd_needs_mode_chk: assert property (@(posedge clk) disable iff (rst)
    line_pd |-> mon_mode);

  // R10
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |=> !cmd_ready);

  // R10
  ready_after_break_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> (!$past(line_pd) && $past(line_pd, 2)));

  // R11
  quiet_rx_chk: assert property (@(posedge clk) disable iff (rst)
    line_pd |-> !sec_valid);

  // R12
  release_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst_pin_n) |-> !line_pd);

endmodule

bind mon_handshake mon_handshake_chk i_chk (
  .clk         (clk),
  .rst         (rst),
  .rst_pin_n   (rst_pin_n),
  .mon_mode    (mon_mode),
  .clk_div_sel (clk_div_sel),
  .line_pd     (line_pd),
  .sec_valid   (sec_valid),
  .cmd_ready   (cmd_ready)
);

// File: tb/test_mon_handshake.sv
`timescale 1ns/1ps
module test_mon_handshake;

  localparam int N4 = 8;
  localparam int N8 = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rst_pin_n = 1'b0;
  logic irq_hv = 1'b0, irq_level = 1'b0, mode_sel = 1'b0, vec_erased = 1'b0;
  logic host_tx = 1'b1;
  logic line_in;
  logic mon_mode, line_pd, clk_div_sel, sec_valid, cmd_ready;
  logic [7:0] sec_data;
  logic [2:0] sec_idx;

  always #2.5 clk = ~clk;

  assign line_in = host_tx & ~line_pd;

  mon_handshake #(.BIT_CYC_4M(N4), .BIT_CYC_8M(N8)) i_mon_handshake (
    .clk(clk), .rst(rst), .rst_pin_n(rst_pin_n), .irq_hv(irq_hv),
    .irq_level(irq_level), .mode_sel(mode_sel), .vec_erased(vec_erased),
    .line_in(line_in), .mon_mode(mon_mode), .line_pd(line_pd),
    .clk_div_sel(clk_div_sel), .sec_data(sec_data), .sec_valid(sec_valid),
    .sec_idx(sec_idx), .cmd_ready(cmd_ready)
  );

  int    cyc = 0;
  int    checks = 0, fails = 0;
  bit    checking = 0, finished = 0;
  bit    e_mon = 0, e_sel = 0, p_mon = 0, p_sel = 0;
  int    p_at = -1, brk_lo = -1, brk_hi = -1, rdy_at = -1;
  int    nbit = N4, sidx = 0;
  string mtag = "R5", vtag = "R7";
  int    q_cyc[$];
  int    q_dat[$];
  int    q_idx[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s cycle %0d: actual %0d expected %0d", tag, what, cyc, act, exp);
    end
  endtask

  // behavioural reference, compared on every clock
  always @(negedge clk) begin
    if (checking && !finished) begin
      bit ev, e_pd, e_rdy;
      if (p_at >= 0 && cyc >= p_at) begin
        e_mon = p_mon; e_sel = p_sel; p_at = -1;
      end
      ev    = (q_cyc.size() > 0) && (q_cyc[0] == cyc);
      e_pd  = (brk_lo >= 0) && (cyc >= brk_lo) && (cyc <= brk_hi);
      e_rdy = (cyc == rdy_at);
      chk(mon_mode == e_mon, mtag, "mon_mode", mon_mode, e_mon);
      chk(clk_div_sel == e_sel, mtag, "clk_div_sel", clk_div_sel, e_sel);
      chk(line_pd == e_pd, "R9", "line_pd", line_pd, e_pd);
      chk(cmd_ready == e_rdy, "R10", "cmd_ready", cmd_ready, e_rdy);
      chk(sec_valid == ev, e_pd ? "R11" : vtag, "sec_valid", sec_valid, ev);
      if (ev) begin
        chk(sec_data == q_dat[0][7:0], "R6", "sec_data", sec_data, q_dat[0]);
        chk(sec_idx == q_idx[0][2:0], "R7", "sec_idx", sec_idx, q_idx[0]);
        void'(q_cyc.pop_front()); void'(q_dat.pop_front()); void'(q_idx.pop_front());
      end
    end
  end

  task automatic enter(input bit hv, input bit lvl, input bit msel,
                       input bit erased, input string tag);
    bit ca, cb, cc;
    @(negedge clk);
    rst_pin_n = 1'b0;
    irq_hv = hv; irq_level = lvl; mode_sel = msel; vec_erased = erased;
    repeat (2) @(negedge clk);
    ca = !erased && hv && lvl && !msel;
    cb = !erased && hv && lvl && msel;
    cc = erased && !hv;
    p_mon = ca || cb || cc;
    p_sel = cb || cc;
    brk_lo = -1; brk_hi = -1; rdy_at = -1; sidx = 0;
    nbit = p_sel ? N8 : N4;
    mtag = tag;
    rst_pin_n = 1'b1;
    p_at = cyc + 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] d, input bit good_stop);
    int e1, v, half;
    @(negedge clk);
    host_tx = 1'b0;
    e1 = cyc + 1;
    half = nbit / 2;
    if (good_stop && p_mon && sidx < 8) begin
      v = e1 + half + 9 * nbit + 2;
      q_cyc.push_back(v); q_dat.push_back(int'(d)); q_idx.push_back(sidx);
      if (sidx == 7) begin
        brk_lo = v + 1;
        brk_hi = v + 10 * nbit;
        rdy_at = v + 10 * nbit + 2;
      end
      sidx++;
    end
    repeat (nbit) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      host_tx = d[i];
      repeat (nbit) @(negedge clk);
    end
    host_tx = good_stop;
    repeat (nbit) @(negedge clk);
    host_tx = 1'b1;
    repeat (2 * nbit) @(negedge clk);
  endtask

  task automatic send_eight(input logic [7:0] seed);
    for (int k = 0; k < 8; k++) send_byte(seed ^ 8'(k * 37 + 1), 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R5: reset state at the ports
    chk(mon_mode == 0 && line_pd == 0 && clk_div_sel == 0 && sec_valid == 0 && cmd_ready == 0,
        "R5", "reset outputs", {mon_mode, line_pd, clk_div_sel, sec_valid, cmd_ready}, 0);
    checking = 1;

    // case A, 4 MHz divisor
    enter(1, 1, 0, 0, "R2");
    send_byte(8'h00, 1); send_byte(8'hFF, 1); send_byte(8'hA5, 1); send_byte(8'h5A, 1);
    send_byte(8'h01, 1); send_byte(8'h80, 1); send_byte(8'h3C, 1); send_byte(8'hC3, 1);
    repeat (12 * nbit) @(negedge clk);
    // R1: pins move after release, latched state must not
    mtag = "R1";
    irq_hv = 0; mode_sel = 1; vec_erased = 1; irq_level = 0;
    repeat (5) @(negedge clk);
    chk(mon_mode == 1 && clk_div_sel == 0, "R1", "mode after pin change",
        {mon_mode, clk_div_sel}, 2);

    // case B, aborted part-way then restarted
    enter(1, 1, 1, 0, "R3");
    send_byte(8'h11, 1); send_byte(8'h22, 1); send_byte(8'h33, 1);
    @(negedge clk);
    rst_pin_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(line_pd == 0 && cmd_ready == 0 && sec_valid == 0, "R12", "abandoned exchange",
        {line_pd, cmd_ready, sec_valid}, 0);
    enter(1, 1, 1, 0, "R3");
    send_eight(8'h6E);
    // R11: host traffic that overlaps the break is not taken
    vtag = "R11";
    send_byte(8'h99, 1);
    repeat (12 * nbit) @(negedge clk);
    vtag = "R7";

    // case C with interrupt pin low, one framing error first
    enter(0, 0, 0, 1, "R4");
    vtag = "R8";
    send_byte(8'h7E, 0);
    repeat (2 * nbit) @(negedge clk);
    vtag = "R7";
    send_eight(8'hB2);
    repeat (12 * nbit) @(negedge clk);

    // case C with interrupt pin high
    enter(0, 1, 1, 1, "R4");
    send_byte(8'h44, 1);
    repeat (4 * nbit) @(negedge clk);

    // no entry case: erased vector with high voltage
    enter(1, 1, 0, 1, "R5");
    send_byte(8'h12, 1); send_byte(8'h34, 1);
    // no entry case: high voltage flag with a low pin level
    enter(1, 0, 0, 0, "R5");
    send_byte(8'h56, 1);
    repeat (4 * nbit) @(negedge clk);
    chk(mon_mode == 0 && line_pd == 0, "R5", "no entry", {mon_mode, line_pd}, 0);
    chk(q_cyc.size() == 0, "R7", "pending strobes", q_cyc.size(), 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog R7: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule